// File: doc/BRIEF.md
# Early-Terminating Survivor Traceback Unit

This unit decodes a survivor-path store for a rate-1/2 convolutional code of constraint length three, with four trellis states. The add-compare-select side hands over one decision vector per trellis step. The vector holds one survivor bit for each state. The unit keeps the last `DEPTH` vectors (fifteen by default, five times the constraint length) in a ring. Beside them it keeps a second ring that holds the route the most recent traceback followed, one state per depth.

Each new vector starts a traceback from a fixed starting state, not from the best-metric state. The unit walks from the newest depth towards older ones, one node per clock. At every node past the newest it compares the state it reached with the state stored for that depth. On a match the two routes have merged, so the rest of the stored route is still correct and the walk stops there. On a mismatch the stored node is overwritten and the walk goes on. The first traceback after reset has no valid route to compare with, so it walks the whole window.

A finished traceback gives one decoded bit and a one-cycle acknowledge. Between requests the unit holds its state and does nothing.

Top module: `tbc_traceback`

## Requirements
- R1: After reset, and whenever no request is pending, `ack` stays 0. After reset `dec_bit` is 0.
- R2: A request is taken only while the unit is idle, meaning `req` is 1 in a cycle with no traceback and no acknowledge under way. `dv` is captured in that cycle only, and changes to `dv` during the traceback have no effect on the result.
- R3: The first traceback after reset compares nothing. It visits all `DEPTH` nodes and writes each state into the route store.
- R4: Every traceback starts at state 0. The predecessor of state `{s1,s0}` is `{dv_d[{s1,s0}], s1}`, where `dv_d` is the vector captured at that depth and bit index `i` of a vector belongs to state `i`.
- R5: At depths 1 to `DEPTH`-1, a node whose state equals the stored state for that depth ends the traceback, and that node counts as visited. A node that differs overwrites the stored state.
- R6: A traceback that finds no match visits exactly `DEPTH` nodes.
- R7: `ack` rises one clock after the last visited node. The number of rising clock edges from the one that accepts the request up to and including the one that raises `ack` equals the number of visited nodes plus one.
- R8: `ack` is high for exactly one cycle per accepted request. `dec_bit` changes only when `ack` rises, and keeps its value until the next acknowledge.
- R9: `dec_bit` is the most significant bit of the stored state at the oldest depth, read after the current traceback has made its updates.
- R10: Each accepted request makes the stored route one depth older. The state that was at the oldest depth is dropped, and the newest depth is written with the start state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req | input | 1 | New decision vector offered. Hold it until `ack` |
| dv | input | 4 | Survivor decision bits, bit i for state i |
| ack | output | 1 | One-cycle pulse when a traceback has finished |
| dec_bit | output | 1 | Decoded bit, updated together with `ack` |

## Verification
The bound checker watches the handshake on every cycle. It checks that `ack` is a single pulse and always follows a finished walk, that no request is taken while a walk is running, that the walk depth stays inside the window, and that no early stop happens before the first acknowledge after reset. Only the bench's scenarios can show the arithmetic. A reference model that keeps its own newest-first arrays rebuilds the predecessor chain, the point of convergence and the decoded bit. It then checks each bit and the request-to-acknowledge latency, which shows how far each walk went, under constant, alternating, random and mid-walk-changing decision vectors.

// File: rtl/tbc_pkg.sv
package tbc_pkg;

  typedef enum logic [1:0] {
    TB_IDLE = 2'd0,
    TB_WALK = 2'd1,
    TB_ACK  = 2'd2
  } tb_phase_e;

  // ring slot that lies k steps older than the head slot
  function automatic int ring_back(input int head, input int k, input int depth);
    return (head >= k) ? head - k : head + depth - k;
  endfunction

  // slot one step newer than the head slot
  function automatic int ring_next(input int head, input int depth);
    return (head == depth - 1) ? 0 : head + 1;
  endfunction

endpackage

// File: rtl/tbc_surv_store.sv
module tbc_surv_store #(
  parameter int NSTATE = 4,
  parameter int DEPTH  = 15,
  localparam int PW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [PW-1:0]     waddr,
  input  logic [NSTATE-1:0] wdata,
  input  logic [PW-1:0]     raddr,
  output logic [NSTATE-1:0] rdata
);

  logic [NSTATE-1:0] row_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_row
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) row_q[g] <= '0;
      else if (we && (waddr == PW'(g))) row_q[g] <= wdata;
    end
  end

  assign rdata = row_q[raddr];

endmodule

// File: rtl/tbc_path_store.sv
module tbc_path_store #(
  parameter int SW    = 2,
  parameter int DEPTH = 15,
  localparam int PW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [PW-1:0] waddr,
  input  logic [SW-1:0] wdata,
  input  logic [PW-1:0] raddr_a,
  output logic [SW-1:0] rdata_a,
  input  logic [PW-1:0] raddr_b,
  output logic [SW-1:0] rdata_b
);

  logic [SW-1:0] node_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_node
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) node_q[g] <= '0;
      else if (we && (waddr == PW'(g))) node_q[g] <= wdata;
    end
  end

  assign rdata_a = node_q[raddr_a];
  assign rdata_b = node_q[raddr_b];

endmodule

// File: rtl/tbc_ctrl.sv
module tbc_ctrl #(
  parameter int NSTATE = 4,
  parameter int DEPTH  = 15,
  parameter int START  = 0,
  localparam int SW    = $clog2(NSTATE),
  localparam int PW    = $clog2(DEPTH),
  localparam int DW    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_i,
  // survivor store
  output logic              sv_we_o,
  output logic [PW-1:0]     sv_waddr_o,
  output logic [PW-1:0]     rd_slot_o,
  input  logic [NSTATE-1:0] sv_row_i,
  // route store
  output logic              pth_we_o,
  output logic [SW-1:0]     pth_wdata_o,
  input  logic [SW-1:0]     pth_node_i,
  output logic [PW-1:0]     old_slot_o,
  input  logic [SW-1:0]     pth_old_i,
  // events
  output logic              acc_o,
  output logic              stop_o,
  output logic              done_o,
  output logic              walk_o,
  output logic [DW-1:0]     depth_o,
  // result
  output logic              ack_o,
  output logic              bit_o
);
  import tbc_pkg::*;

  // predecessor: shift right, survivor bit enters as MSB
  function automatic logic [SW-1:0] pred_of(input logic [SW-1:0] s, input logic d);
    return {d, s[SW-1:1]};
  endfunction

  tb_phase_e     phase_q;
  logic [PW-1:0] head_q;
  logic [DW-1:0] depth_q;
  logic [SW-1:0] cur_q;
  logic          primed_q;
  logic          ack_q;
  logic          bit_q;

  logic [PW-1:0] head_nxt;
  logic          walking, match, last_node;
  logic [SW-1:0] oldest_state;

  assign head_nxt   = PW'(ring_next(int'(head_q), DEPTH));
  assign rd_slot_o  = PW'(ring_back(int'(head_q), int'(depth_q), DEPTH));
  assign old_slot_o = PW'(ring_back(int'(head_q), DEPTH - 1, DEPTH));

  assign walking   = (phase_q == TB_WALK);
  assign match     = walking && primed_q && (depth_q != '0) && (cur_q == pth_node_i);
  assign last_node = walking && (depth_q == DW'(DEPTH - 1));

  assign acc_o   = (phase_q == TB_IDLE) && req_i;
  assign stop_o  = match;
  assign done_o  = match || last_node;
  assign walk_o  = walking;
  assign depth_o = depth_q;

  assign sv_we_o     = acc_o;
  assign sv_waddr_o  = head_nxt;
  assign pth_we_o    = walking && !match;
  assign pth_wdata_o = cur_q;

  // the oldest node is being written in this cycle only on a full walk
  assign oldest_state = (last_node && !match) ? cur_q : pth_old_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q  <= TB_IDLE;
      head_q   <= '0;
      depth_q  <= '0;
      cur_q    <= '0;
      primed_q <= 1'b0;
      ack_q    <= 1'b0;
      bit_q    <= 1'b0;
    end else begin
      unique case (phase_q)
        TB_IDLE: begin
          if (req_i) begin
            head_q  <= head_nxt;
            depth_q <= '0;
            cur_q   <= SW'(START);
            phase_q <= TB_WALK;
          end
        end
        TB_WALK: begin
          if (done_o) begin
            ack_q    <= 1'b1;
            bit_q    <= oldest_state[SW-1];
            primed_q <= 1'b1;
            phase_q  <= TB_ACK;
          end else begin
            depth_q <= depth_q + 1'b1;
            cur_q   <= pred_of(cur_q, sv_row_i[cur_q]);
          end
        end
        TB_ACK: begin
          ack_q   <= 1'b0;
          phase_q <= TB_IDLE;
        end
        default: phase_q <= TB_IDLE;
      endcase
    end
  end

  assign ack_o = ack_q;
  assign bit_o = bit_q;

endmodule

// File: rtl/tbc_traceback.sv
module tbc_traceback #(
  parameter int K      = 3,
  parameter int START  = 0,
  localparam int NSTATE = 1 << (K - 1),
  localparam int SW     = K - 1,
  localparam int DEPTH  = 5 * K,
  localparam int PW     = $clog2(DEPTH),
  localparam int DW     = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic [NSTATE-1:0] dv,
  output logic              ack,
  output logic              dec_bit
);

  logic              sv_we;
  logic [PW-1:0]     sv_waddr, rd_slot, old_slot;
  logic [NSTATE-1:0] sv_row;
  logic              pth_we;
  logic [SW-1:0]     pth_wdata, pth_node, pth_old;
  logic              acc_evt, stop_evt, done_evt, walking;
  logic [DW-1:0]     node_depth;

  tbc_surv_store #(.NSTATE(NSTATE), .DEPTH(DEPTH)) u_surv (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (sv_we),
    .waddr (sv_waddr),
    .wdata (dv),
    .raddr (rd_slot),
    .rdata (sv_row)
  );

  tbc_path_store #(.SW(SW), .DEPTH(DEPTH)) u_path (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (pth_we),
    .waddr   (rd_slot),
    .wdata   (pth_wdata),
    .raddr_a (rd_slot),
    .rdata_a (pth_node),
    .raddr_b (old_slot),
    .rdata_b (pth_old)
  );

  tbc_ctrl #(.NSTATE(NSTATE), .DEPTH(DEPTH), .START(START)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_i       (req),
    .sv_we_o     (sv_we),
    .sv_waddr_o  (sv_waddr),
    .rd_slot_o   (rd_slot),
    .sv_row_i    (sv_row),
    .pth_we_o    (pth_we),
    .pth_wdata_o (pth_wdata),
    .pth_node_i  (pth_node),
    .old_slot_o  (old_slot),
    .pth_old_i   (pth_old),
    .acc_o       (acc_evt),
    .stop_o      (stop_evt),
    .done_o      (done_evt),
    .walk_o      (walking),
    .depth_o     (node_depth),
    .ack_o       (ack),
    .bit_o       (dec_bit)
  );

endmodule

// File: rtl/tbc_traceback_chk.sv
module tbc_traceback_chk #(
  parameter int DEPTH = 15,
  parameter int DW    = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ack,
  input logic          acc_evt,
  input logic          stop_evt,
  input logic          done_evt,
  input logic          walking,
  input logic [DW-1:0] node_depth
);

  logic acked_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acked_q <= 1'b0;
    else if (ack) acked_q <= 1'b1;
  end

  // R8
  ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !ack);

  // R7
  ack_follows_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |=> ack);

  // R7
  ack_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack) |-> $past(done_evt));

  // R2
  no_accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    walking |-> !acc_evt);

  // R3
  no_early_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |-> acked_q);

  // R6
  depth_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    walking |-> (node_depth < DW'(DEPTH)));

endmodule

bind tbc_traceback tbc_traceback_chk #(.DEPTH(DEPTH), .DW(DW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ack        (ack),
  .acc_evt    (acc_evt),
  .stop_evt   (stop_evt),
  .done_evt   (done_evt),
  .walking    (walking),
  .node_depth (node_depth)
);

// File: tb/tbc_traceback_test.sv
`timescale 1ns/1ps
module tbc_traceback_test;
  localparam int D = 15;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req = 1'b0;
  logic [3:0] dv = '0;
  logic       ack;
  logic       dec_bit;

  int checks = 0;
  int failures = 0;
  int cyc = 0;

  tbc_traceback uut (.clk(clk), .rst_n(rst_n), .req(req), .dv(dv), .ack(ack), .dec_bit(dec_bit));

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // reference model: index 0 is the newest depth
  logic [3:0] m_sv [D];
  logic [1:0] m_path [D];
  bit         m_primed = 0;

  bit exp_bit_q[$];
  int exp_len_q[$];
  int stamp_q[$];
  bit last_bit = 0;
  bit prev_ack = 0;

  task automatic check(input bit ok, input string req_tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req_tag, act, exp, cyc);
    end
  endtask

  // R10 ages the route, R4 predecessor rule, R5 convergence, R3/R6 walk length, R9 output bit
  task automatic model_step(input logic [3:0] v, output bit b, output int nodes);
    logic [1:0] s;
    for (int d = D - 1; d > 0; d--) begin
      m_sv[d]   = m_sv[d-1];
      m_path[d] = m_path[d-1];
    end
    m_sv[0] = v;
    s = 2'd0;
    nodes = D;
    for (int d = 0; d < D; d++) begin
      if (d != 0 && m_primed && s == m_path[d]) begin
        nodes = d + 1;
        break;
      end
      m_path[d] = s;
      if (d < D - 1) s = {m_sv[d][s], s[1]};
    end
    m_primed = 1;
    b = m_path[D-1][1];
  endtask

  // driver: pushes the expected result, then runs the handshake
  task automatic send(input logic [3:0] v, input bit flip_mid);
    bit b;
    int n;
    model_step(v, b, n);
    exp_bit_q.push_back(b);
    exp_len_q.push_back(n + 1);
    @(negedge clk);
    stamp_q.push_back(cyc);
    req = 1'b1;
    dv  = v;
    if (flip_mid) begin
      @(negedge clk);
      dv = ~v;          // R2: ignored after acceptance
    end
    do @(negedge clk); while (!ack);
    req = 1'b0;
    dv  = 4'($urandom);
  endtask

  // monitor: pops expectations as acknowledges appear
  always @(negedge clk) begin
    if (rst_n) begin
      if (ack) begin
        check(!prev_ack, "R8 single-cycle ack", int'(prev_ack), 0);
        if (exp_bit_q.size() == 0) begin
          check(0, "R1 unexpected ack", 1, 0);
        end else begin
          bit eb;
          int el, st;
          eb = exp_bit_q.pop_front();
          el = exp_len_q.pop_front();
          st = stamp_q.pop_front();
          check(dec_bit == eb, "R9 decoded bit", int'(dec_bit), int'(eb));
          check((cyc - st) == el, "R7/R5 latency", cyc - st, el);
          last_bit = dec_bit;
        end
      end
      prev_ack = ack;
    end
  end

  task automatic idle_check(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check(ack == 1'b0, "R1 no ack while idle", int'(ack), 0);
      check(dec_bit == last_bit, "R8 bit held", int'(dec_bit), int'(last_bit));
    end
  endtask

  initial begin
    for (int d = 0; d < D; d++) begin
      m_sv[d] = '0;
      m_path[d] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(ack == 1'b0, "R1 reset ack", int'(ack), 0);
    check(dec_bit == 1'b0, "R1 reset bit", int'(dec_bit), 0);
    idle_check(4);

    send(4'b1111, 0);           // R3 full first walk
    idle_check(3);
    for (int i = 0; i < 6; i++) send(4'b0000, 0);   // R5 quick merges
    for (int i = 0; i < 20; i++) send(i[0] ? 4'b1010 : 4'b0101, 0); // R4 alternating
    for (int i = 0; i < 8; i++) send(4'b1111, 0);
    for (int i = 0; i < 10; i++) send(4'($urandom), 1); // R2 dv change mid-walk
    idle_check(5);
    for (int i = 0; i < 200; i++) send(4'($urandom), 0); // R6/R10 random traffic
    idle_check(5);
    check(exp_bit_q.size() == 0, "R8 every request acknowledged", exp_bit_q.size(), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #400000;
    failures++;
    checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule